// File: doc/BRIEF.md
# Banked Timer-Match Interrupt

This block keeps one free-running event counter that every CPU of a cluster shares, and gives each CPU a private comparator against it. Each CPU owns a 64-bit match value, a sticky match flag and an interrupt enable. When the counter reaches a CPU's match value, that CPU's flag is set. If the CPU's enable is on, its interrupt/wakeup line goes high and stays high until software clears the flag. The counter steps by one on each cycle with `tick_en` high and wraps from all ones back to zero.

All CPUs use the same three register addresses. The `req_cpu` field of the register request picks which CPU's copy a read returns or a write changes. A match value is written in two 32-bit halves. The low half waits in a per-CPU shadow register, and the whole 64-bit value takes effect only when the high half is written. A half-written value therefore never triggers a match. The flag is cleared by writing 1 to control bit 0. The flag is set on the cycle the counter becomes equal to the match value, not while it stays equal.

The register port is a valid/ready stream. A request is accepted on a rising edge with `req_valid` and `req_ready` both high. A write takes effect at that edge and returns no response. A read returns one response beat, registered at the accepting edge. That beat holds `rsp_valid` and `rsp_rdata` steady until `rsp_ready` is high. While a response waits, `req_ready` is low, so back-pressure on the response side stalls new requests.

Top module: `banked_match_irq`

## Requirements
- R1: The counter on `timer_value` increases by exactly one after each rising edge with `tick_en` high and holds its value when `tick_en` is low. It starts at 0 after reset.
- R2: After reset, every CPU's control word reads 0, every `irq` bit is low and `rsp_valid` is low.
- R3: A write to the low match half (address 0) changes nothing that is compared until the high half (address 1) is written. A read of address 0 returns the low half of the active match value, not the shadow. No flag is set by a value that has been only partly written.
- R4: A CPU's flag (control bit 0) goes to 1 on the edge after the cycle in which `timer_value` first equals that CPU's active match value. This includes the case where writing the high half makes the match value equal to the current count.
- R5: Once set, the flag stays 1. Writing the control word with bit 0 = 0 leaves the flag unchanged. Writing bit 0 = 1 clears it.
- R6: After a clear, the flag is not set again while the counter stays equal to the match value. A new match needs the equality to go away and come back.
- R7: If a write-1 clear is accepted on the same edge at which the same CPU's flag is being set, the flag ends at 1.
- R8: Control bit 1 is the enable. `irq[n]` is high exactly when CPU n's flag and enable are both 1. With the enable at 0, `irq[n]` stays low even while the flag is 1.
- R9: Registers are banked. A read returns the copy of the CPU named by `req_cpu`, and a write changes only that CPU's copy.
- R10: Control word bits 31 down to 2 read as 0 whatever was written to them.
- R11: A read response holds `rsp_valid` and `rsp_rdata` stable until `rsp_ready` is high. While the response is pending and not accepted, `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | 2 | CPU whose register copy is accessed |
| req_addr | input | 2 | 0 = match low, 1 = match high, 2 = control |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response can be taken |
| rsp_rdata | output | 32 | Read response data |
| timer_value | output | 64 | Shared event counter |
| irq | output | 4 | Per-CPU interrupt/wakeup request |

## Verification
A register write changes state at its accepting edge. A read response appears in the cycle after acceptance. A flag is set one edge after the counter shows the match value, and `irq` follows on that same edge, since it is a gate on registered state. The bench drives on falling edges and samples shortly after them. Reads go through a scoreboard queue that the monitor empties only on response beats that are handshaken. The irq and counter checks sit on the exact falling edge that comes after the expected register update. The set-versus-clear collision is driven as two back-to-back requests so that the clear lands on the edge where the set falls due.

// File: rtl/bmi_pkg.sv
package bmi_pkg;
  typedef enum logic [1:0] {
    SEL_MATCH_LO = 2'd0,
    SEL_MATCH_HI = 2'd1,
    SEL_CTRL     = 2'd2
  } reg_sel_e;

  localparam int FLAG_BIT = 0;
  localparam int EN_BIT   = 1;
endpackage

// File: rtl/bmi_counter.sv
module bmi_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (tick_en) count <= count + CNT_W'(1);
  end

  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> count == $past(count) + CNT_W'(1));
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(count));
endmodule

// File: rtl/bmi_bank.sv
module bmi_bank #(
  parameter int DATA_W = 32,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  match_val,
  output logic              flag,
  output logic              en,
  output logic              irq
);
  import bmi_pkg::*;

  logic [DATA_W-1:0] shadow_q;
  logic              eq, eq_q, hit, clr_req;

  assign eq      = (count == match_val);
  assign hit     = eq && !eq_q;
  assign clr_req = wr_ctrl && wdata[FLAG_BIT];
  assign irq     = flag && en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q  <= '0;
      match_val <= '0;
      eq_q      <= 1'b1;
      flag      <= 1'b0;
      en        <= 1'b0;
    end else begin
      eq_q <= eq;
      if (wr_lo) shadow_q  <= wdata;
      if (wr_hi) match_val <= {wdata, shadow_q};
      if (hit)          flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
      if (wr_ctrl) en <= wdata[EN_BIT];
    end
  end

  a_r3_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> $stable(match_val));
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  a_r6_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !hit) |=> !flag);
  a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq);
endmodule

// File: rtl/banked_match_irq.sv
module banked_match_irq #(
  parameter int NUM_CPU = 4,
  parameter int DATA_W  = 32,
  localparam int CNT_W  = 2 * DATA_W,
  localparam int ID_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ID_W-1:0]    req_cpu,
  input  logic [1:0]         req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic [CNT_W-1:0]   timer_value,
  output logic [NUM_CPU-1:0] irq
);
  import bmi_pkg::*;

  logic              accept, wr_acc;
  logic [CNT_W-1:0]  match_a [NUM_CPU];
  logic [NUM_CPU-1:0] flag_a, en_a;
  logic [DATA_W-1:0] rd_data;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_acc    = accept && req_write;

  bmi_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .count(timer_value)
  );

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_bank
    logic sel;
    assign sel = wr_acc && (req_cpu == ID_W'(g));
    bmi_bank #(.DATA_W(DATA_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .count    (timer_value),
      .wr_lo    (sel && (req_addr == SEL_MATCH_LO)),
      .wr_hi    (sel && (req_addr == SEL_MATCH_HI)),
      .wr_ctrl  (sel && (req_addr == SEL_CTRL)),
      .wdata    (req_wdata),
      .match_val(match_a[g]),
      .flag     (flag_a[g]),
      .en       (en_a[g]),
      .irq      (irq[g])
    );
  end

  always_comb begin
    rd_data = '0;
    if (int'(req_cpu) < NUM_CPU) begin
      case (reg_sel_e'(req_addr))
        SEL_MATCH_LO: rd_data = match_a[req_cpu][DATA_W-1:0];
        SEL_MATCH_HI: rd_data = match_a[req_cpu][CNT_W-1:DATA_W];
        SEL_CTRL:     rd_data = {{(DATA_W-2){1'b0}}, en_a[req_cpu], flag_a[req_cpu]};
        default:      rd_data = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  a_r10_ctrl_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && req_addr == SEL_CTRL) |=> (rsp_rdata[DATA_W-1:2] == '0));
endmodule

// File: tb/banked_match_irq_test.sv
module banked_match_irq_test;
  localparam int NCPU = 4;
  localparam int DW   = 32;
  localparam int CW   = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0;
  logic          req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [1:0]    req_cpu = '0, req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid, rsp_ready = 1'b1;
  logic [DW-1:0] rsp_rdata;
  logic [CW-1:0] timer_value;
  logic [NCPU-1:0] irq;

  always #10 clk = ~clk;

  banked_match_irq uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_cpu(req_cpu), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .timer_value(timer_value), .irq(irq)
  );

  typedef struct { logic [DW-1:0] val; string tag; } exp_t;
  exp_t sb[$];
  int n_chk = 0, n_fail = 0;

  task automatic check(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: pops the scoreboard on each handshaken response beat
  always begin
    @(negedge clk); #2;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb.size() == 0) check("R11 unexpected response", 64'(rsp_rdata), 64'hDEAD);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, 64'(rsp_rdata), 64'(e.val));
      end
    end
  end

  task automatic bus(bit wr, int cpu, logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_cpu = 2'(cpu); req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(int cpu, logic [1:0] a, logic [DW-1:0] d);
    bus(1'b1, cpu, a, d);
  endtask

  task automatic rd(int cpu, logic [1:0] a, logic [DW-1:0] exp, string tag);
    exp_t e;
    e.val = exp; e.tag = tag;
    sb.push_back(e);
    bus(1'b0, cpu, a, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog expired", 64'd1, 64'd0);
    finish_run();
  end

  initial begin
    logic [CW-1:0] c, m1;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // R2 reset state
    check("R2 irq after reset", 64'(irq), 64'd0);
    check("R2 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check("R1 counter starts at zero", timer_value, 64'd0);
    for (int i = 0; i < NCPU; i++) rd(i, 2'd2, 32'd0, "R2 ctrl reset value");

    // R1 counting and holding
    @(negedge clk); tick_en = 1'b1;
    repeat (10) @(negedge clk);
    tick_en = 1'b0; #2;
    check("R1 ten ticks", timer_value, 64'd10);
    repeat (5) @(negedge clk); #2;
    check("R1 hold with tick_en low", timer_value, 64'd10);

    // R3 low half alone does not arm the compare
    wr(0, 2'd2, 32'd2);
    c = timer_value;
    wr(0, 2'd0, 32'(c + 8));
    rd(0, 2'd0, 32'd0, "R3 low readback is active value");
    tick_en = 1'b1;
    repeat (15) @(negedge clk);
    tick_en = 1'b0; #2;
    check("R3 no irq on partial value", 64'(irq[0]), 64'd0);
    rd(0, 2'd2, 32'd2, "R3 flag clear after partial write");

    // R4 flag one edge after equality
    c = timer_value;
    wr(0, 2'd0, 32'(c + 6));
    wr(0, 2'd1, 32'd0);
    rd(0, 2'd0, 32'(c + 6), "R4 low committed");
    rd(0, 2'd1, 32'd0, "R4 high committed");
    @(negedge clk); tick_en = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk); #2;
      if (timer_value == c + 6) seen = 1'b1;
    end
    check("R4 irq low in matching cycle", 64'(irq[0]), 64'd0);
    @(negedge clk); #2;
    check("R4 irq high one edge later", 64'(irq), 64'd1);
    tick_en = 1'b0;
    rd(0, 2'd2, 32'd3, "R4 flag set");

    // R5 sticky, write-0 ignored, write-1 clears
    wr(0, 2'd2, 32'd2);
    rd(0, 2'd2, 32'd3, "R5 write 0 keeps flag");
    wr(0, 2'd2, 32'd3);
    rd(0, 2'd2, 32'd2, "R5 write 1 clears");
    #2 check("R5 irq low after clear", 64'(irq[0]), 64'd0);

    // R8 enable gates the request line
    m1 = timer_value + 4;
    wr(1, 2'd0, 32'(m1));
    wr(1, 2'd1, 32'd0);
    @(negedge clk); tick_en = 1'b1;
    seen = 1'b0;
    repeat (10) begin @(negedge clk); #2; if (irq[1]) seen = 1'b1; end
    tick_en = 1'b0;
    check("R8 irq blocked while disabled", 64'(seen), 64'd0);
    rd(1, 2'd2, 32'd1, "R8 flag set while disabled");
    wr(1, 2'd2, 32'd2);
    #2 check("R8 irq follows flag once enabled", 64'(irq[1]), 64'd1);

    // R9 banking
    rd(0, 2'd2, 32'd2, "R9 cpu0 ctrl");
    rd(1, 2'd2, 32'd3, "R9 cpu1 ctrl");
    rd(2, 2'd2, 32'd0, "R9 cpu2 ctrl");
    rd(2, 2'd1, 32'd0, "R9 cpu2 match high");
    rd(1, 2'd0, 32'(m1), "R9 cpu1 match low");
    wr(1, 2'd2, 32'd3);
    rd(0, 2'd2, 32'd2, "R9 cpu0 untouched by cpu1 clear");
    rd(1, 2'd2, 32'd2, "R9 cpu1 cleared");

    // R6 no re-set while equality persists
    wr(2, 2'd2, 32'd2);
    c = timer_value;
    wr(2, 2'd0, 32'(c));
    wr(2, 2'd1, 32'(c >> 32));
    rd(2, 2'd2, 32'd3, "R6 set when commit creates equality");
    wr(2, 2'd2, 32'd3);
    repeat (3) @(negedge clk);
    rd(2, 2'd2, 32'd2, "R6 stays clear while equal");
    #2 check("R6 irq stays low", 64'(irq[2]), 64'd0);

    // R7 set wins over simultaneous clear
    wr(3, 2'd2, 32'd2);
    c = timer_value;
    wr(3, 2'd0, 32'(c));
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_cpu = 2'd3; req_addr = 2'd1; req_wdata = 32'(c >> 32);
    @(negedge clk);
    req_addr = 2'd2; req_wdata = 32'd3;
    @(negedge clk);
    req_valid = 1'b0;
    rd(3, 2'd2, 32'd3, "R7 flag kept on collision");
    #2 check("R7 irq high", 64'(irq[3]), 64'd1);

    // R10 upper control bits read zero
    wr(3, 2'd2, 32'hFFFF_FFFE);
    rd(3, 2'd2, 32'd3, "R10 upper bits zero cpu3");
    wr(0, 2'd2, 32'hFFFF_FFFC);
    rd(0, 2'd2, 32'd0, "R10 upper bits zero cpu0");

    // R11 back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    rd(1, 2'd0, 32'(m1), "R11 held response data");
    fork
      rd(1, 2'd2, 32'd2, "R11 stalled read");
      begin
        repeat (3) begin
          @(negedge clk); #2;
          check("R11 rsp_valid held", 64'(rsp_valid), 64'd1);
          check("R11 req_ready low", 64'(req_ready), 64'd0);
          check("R11 rdata stable", 64'(rsp_rdata), 64'(m1));
        end
        @(negedge clk); rsp_ready = 1'b1;
      end
    join
    repeat (4) @(negedge clk);
    check("R11 scoreboard drained", 64'(sb.size()), 64'd0);
    finish_run();
  end
endmodule